// File: doc/BRIEF.md
# Radix-2 Montgomery Modular Multiplier

This block multiplies two residues and divides by a power of two in the same step. Given an odd modulus N of WIDTH bits and operands X and Y that are both below N, it returns X·Y·2^-WIDTH mod N. It is the multiply step used inside modular exponentiation, where operands are kept in Montgomery form by logic outside this block.

The multiplier X is consumed one bit per clock, least significant bit first. Each step adds x_k·Y and q·N to a running sum and halves it. The quotient bit q makes the sum even, so the halving is an exact shift. The running sum is kept as two redundant vectors, sum and carry, so no carry ripples across the word during the loop. After the last step, a block-lookahead adder merges the two vectors. A final compare then subtracts N once if the merged value is not already below N.

A caller raises `start` for one cycle while `busy` is low. The operands are captured on that edge. `done` pulses one cycle later by WIDTH+2 clock edges, and `result` then holds until the next accepted start.

Top module: `mont_mul_r2`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is 0, `done` is 0 and `result` is 0 until the first accepted start.
- R2: For odd N, X < N and Y < N, the reported `result` r satisfies r < N and r·2^WIDTH ≡ X·Y (mod N).
- R3: `done` rises exactly WIDTH+2 rising clock edges after the edge on which `start` was accepted.
- R4: `busy` is 1 in every cycle between an accepted start and its `done`, and it is 0 in the cycle `done` is 1.
- R5: `done` is high for exactly one cycle per accepted start.
- R6: A `start` raised while `busy` is 1 is ignored: the running operation keeps its operands and its completion time.
- R7: `result` changes only in the cycle `done` is 1, and it holds its value until the next completion.
- R8: The operands and modulus are sampled on the accepted start edge. Later changes on those inputs do not affect the running operation.
- R9: A zero operand (X = 0 or Y = 0) gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin, taken only while idle |
| op_x | input | WIDTH | Multiplier X, scanned from its LSB |
| op_y | input | WIDTH | Multiplicand Y |
| modulus | input | WIDTH | Odd modulus N |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | WIDTH | X·Y·2^-WIDTH mod N, held between completions |

## Verification
The range check on `result` only holds when the captured modulus is odd and both operands are below it. Under those conditions the redundant sum never reaches 2N, and one subtraction is always enough. The stimulus therefore draws every modulus from a list of odd values, and it draws each X and Y from 0 up to N−1. The timing properties only assume that `start` is sampled while idle. The bench deliberately raises `start` and changes the operand inputs in mid-run, to confirm that the block ignores them.

// File: rtl/mont_pkg.sv
package mont_pkg;

   // Control sequence of one multiplication
   typedef enum logic [1:0] {
      MM_IDLE = 2'd0,
      MM_ITER = 2'd1,
      MM_SUM  = 2'd2,
      MM_FIX  = 2'd3
   } mm_state_e;

   // Cycles spent after the bit loop: one merge, one correction
   localparam int unsigned MM_TAIL_CYCLES = 2;

endpackage

// File: rtl/mont_csa_step.sv
// One radix-2 iteration on a redundant (sum, carry) accumulator.
module mont_csa_step #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH+1:0] s_in,
   input  logic [WIDTH+1:0] c_in,
   input  logic             x_bit,
   input  logic [WIDTH-1:0] y_val,
   input  logic [WIDTH-1:0] n_val,
   output logic [WIDTH+1:0] s_out,
   output logic [WIDTH+1:0] c_out
);

   localparam int unsigned AW = WIDTH + 2;

   logic          q_bit;
   logic [AW-1:0] y_term;
   logic [AW-1:0] n_term;
   logic [AW-1:0] s1;
   logic [AW-2:0] m1;
   logic [AW-1:0] c1;
   logic [AW-1:1] s2;
   logic [AW-2:0] m2;

   // Parity of the redundant value plus the x_k*y0 term
   assign q_bit  = s_in[0] ^ c_in[0] ^ (x_bit & y_val[0]);
   assign y_term = x_bit ? {2'b00, y_val} : '0;
   assign n_term = q_bit ? {2'b00, n_val} : '0;

   genvar i;

   // First 3:2 layer: accumulator plus x_k*Y
   for (i = 0; i < AW; i++) begin : g_l1_sum
      assign s1[i] = s_in[i] ^ c_in[i] ^ y_term[i];
   end
   for (i = 0; i < AW - 1; i++) begin : g_l1_maj
      assign m1[i] = (s_in[i] & c_in[i]) | (s_in[i] & y_term[i]) | (c_in[i] & y_term[i]);
   end
   assign c1 = {m1, 1'b0};

   // Second 3:2 layer: plus q*N; bit 0 of the sum is zero by choice of q
   for (i = 1; i < AW; i++) begin : g_l2_sum
      assign s2[i] = s1[i] ^ c1[i] ^ n_term[i];
   end
   for (i = 0; i < AW - 1; i++) begin : g_l2_maj
      assign m2[i] = (s1[i] & c1[i]) | (s1[i] & n_term[i]) | (c1[i] & n_term[i]);
   end

   // Exact halving of both vectors
   assign s_out = {1'b0, s2};
   assign c_out = {1'b0, m2};

endmodule

// File: rtl/mont_cla_adder.sv
// Block carry-lookahead adder; carry out of the top bit is not produced.
module mont_cla_adder #(
   parameter int unsigned AW  = 34,
   parameter int unsigned BLK = 4
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   output logic [AW-1:0] sum
);

   localparam int unsigned NG = (AW + BLK - 1) / BLK;

   logic [AW-2:0] gen;
   logic [AW-1:0] prop;
   logic [AW-1:0] cy;

   assign gen  = a[AW-2:0] & b[AW-2:0];
   assign prop = a ^ b;

   if (NG == 1) begin : g_one_block
      always_comb begin
         cy[0] = 1'b0;
         for (int idx = 1; idx < AW; idx++) begin
            cy[idx] = gen[idx-1] | (prop[idx-1] & cy[idx-1]);
         end
      end
   end else begin : g_multi_block
      logic [NG-2:0] blk_g;
      logic [NG-2:0] blk_p;
      logic [NG-1:0] blk_cin;

      always_comb begin
         // Group generate / propagate for every block below the top one
         for (int k = 0; k < NG - 1; k++) begin
            blk_g[k] = 1'b0;
            blk_p[k] = 1'b1;
            for (int j = 0; j < BLK; j++) begin
               blk_g[k] = gen[k*BLK+j] | (prop[k*BLK+j] & blk_g[k]);
               blk_p[k] = blk_p[k] & prop[k*BLK+j];
            end
         end
         // Lookahead chain across blocks
         blk_cin[0] = 1'b0;
         for (int k = 1; k < NG; k++) begin
            blk_cin[k] = blk_g[k-1] | (blk_p[k-1] & blk_cin[k-1]);
         end
         // Carries inside each block start from its lookahead carry
         for (int idx = 0; idx < AW; idx++) begin
            if (idx % BLK == 0) begin
               cy[idx] = blk_cin[idx/BLK];
            end else begin
               cy[idx] = gen[idx-1] | (prop[idx-1] & cy[idx-1]);
            end
         end
      end
   end

   assign sum = prop ^ cy;

endmodule

// File: rtl/mont_cond_sub.sv
// Maps a value in [0, 2N) into [0, N) with at most one subtraction.
module mont_cond_sub #(
   parameter int unsigned WIDTH = 32
) (
   input  logic [WIDTH+1:0] val,
   input  logic [WIDTH-1:0] n_val,
   output logic [WIDTH-1:0] r
);

   logic below;

   assign below = val < {2'b00, n_val};
   assign r     = below ? val[WIDTH-1:0] : (val[WIDTH-1:0] - n_val);

endmodule

// File: rtl/mont_mul_r2.sv
module mont_mul_r2
   import mont_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned CLA_BLK = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [WIDTH-1:0] op_x,
   input  logic [WIDTH-1:0] op_y,
   input  logic [WIDTH-1:0] modulus,
   output logic             busy,
   output logic             done,
   output logic [WIDTH-1:0] result
);

   localparam int unsigned AW      = WIDTH + 2;
   localparam int unsigned CW      = (WIDTH > 1) ? $clog2(WIDTH) : 1;
   localparam int unsigned LATENCY = WIDTH + MM_TAIL_CYCLES;

   if (WIDTH < 2) begin : g_bad_width
      $error("mont_mul_r2: WIDTH must be at least 2");
   end
   if (CLA_BLK < 1 || CLA_BLK > AW) begin : g_bad_blk
      $error("mont_mul_r2: CLA_BLK must lie in 1..WIDTH+2");
   end
   if (LATENCY != WIDTH + 2) begin : g_bad_tail
      $error("mont_mul_r2: tail cycle count mismatch");
   end

   mm_state_e     state;
   logic [CW-1:0] bit_cnt;
   logic [WIDTH-1:0] x_sh;
   logic [WIDTH-1:0] y_q;
   logic [WIDTH-1:0] n_q;
   logic [AW-1:0] acc_s;
   logic [AW-1:0] acc_c;
   logic [AW-1:0] merged_q;
   logic [WIDTH-1:0] res_q;
   logic          done_q;

   logic [AW-1:0] nxt_s;
   logic [AW-1:0] nxt_c;
   logic [AW-1:0] merged;
   logic [WIDTH-1:0] reduced;

   mont_csa_step #(.WIDTH(WIDTH)) u_step (
      .s_in  (acc_s),
      .c_in  (acc_c),
      .x_bit (x_sh[0]),
      .y_val (y_q),
      .n_val (n_q),
      .s_out (nxt_s),
      .c_out (nxt_c)
   );

   mont_cla_adder #(.AW(AW), .BLK(CLA_BLK)) u_merge (
      .a   (acc_s),
      .b   (acc_c),
      .sum (merged)
   );

   mont_cond_sub #(.WIDTH(WIDTH)) u_fix (
      .val   (merged_q),
      .n_val (n_q),
      .r     (reduced)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= MM_IDLE;
         bit_cnt  <= '0;
         x_sh     <= '0;
         y_q      <= '0;
         n_q      <= '0;
         acc_s    <= '0;
         acc_c    <= '0;
         merged_q <= '0;
         res_q    <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            MM_IDLE: begin
               if (start) begin
                  x_sh    <= op_x;
                  y_q     <= op_y;
                  n_q     <= modulus;
                  acc_s   <= '0;
                  acc_c   <= '0;
                  bit_cnt <= '0;
                  state   <= MM_ITER;
               end
            end
            MM_ITER: begin
               acc_s   <= nxt_s;
               acc_c   <= nxt_c;
               x_sh    <= {1'b0, x_sh[WIDTH-1:1]};
               bit_cnt <= bit_cnt + CW'(1);
               if (bit_cnt == CW'(WIDTH - 1)) begin
                  state <= MM_SUM;
               end
            end
            MM_SUM: begin
               merged_q <= merged;
               state    <= MM_FIX;
            end
            MM_FIX: begin
               res_q  <= reduced;
               done_q <= 1'b1;
               state  <= MM_IDLE;
            end
            default: state <= MM_IDLE;
         endcase
      end
   end

   assign busy   = (state != MM_IDLE);
   assign done   = done_q;
   assign result = res_q;

endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
   parameter int unsigned WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic [WIDTH-1:0] modulus,
   input logic [WIDTH-1:0] result
);

   logic [15:0]      lat_cnt;
   logic [WIDTH-1:0] n_cap;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lat_cnt <= '0;
         n_cap   <= '0;
      end else if (start && !busy) begin
         lat_cnt <= '0;
         n_cap   <= modulus;
      end else if (busy) begin
         lat_cnt <= lat_cnt + 16'd1;
      end
   end

   // R3
   latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_cnt == 16'(WIDTH + 2)));

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R4
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R2
   result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (result < n_cap));

endmodule

bind mont_mul_r2 mont_mul_chk #(.WIDTH(WIDTH)) u_mm_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .modulus (modulus),
   .result  (result)
);

// File: tb/tb_mont_mul_r2.sv
module tb_mont_mul_r2;

   localparam int TW  = 8;
   localparam int LAT = TW + 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [TW-1:0] op_x = '0;
   logic [TW-1:0] op_y = '0;
   logic [TW-1:0] modulus = '0;
   logic          busy;
   logic          done;
   logic [TW-1:0] result;

   int tests = 0;
   int fails = 0;
   int cyc   = 0;

   always #5 clk = ~clk;

   mont_mul_r2 #(.WIDTH(TW), .CLA_BLK(3)) dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .op_x    (op_x),
      .op_y    (op_y),
      .modulus (modulus),
      .busy    (busy),
      .done    (done),
      .result  (result)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic bit mont_ok(input int x, input int y, input int n, input int r);
      return (r >= 0) && (r < n) && (((r * (1 << TW)) % n) == ((x * y) % n));
   endfunction

   // Reference residue by search (r*2^TW == x*y mod n, r < n)
   function automatic int mont_ref(input int x, input int y, input int n);
      for (int r = 0; r < n; r++) begin
         if (((r * (1 << TW)) % n) == ((x * y) % n)) return r;
      end
      return -1;
   endfunction

   task automatic run_op(input int x, input int y, input int n,
                         output int res, output int lat);
      @(negedge clk);
      op_x = TW'(x); op_y = TW'(y); modulus = TW'(n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      res = int'(result);
   endtask

   task automatic sweep_one(input int x, input int y, input int n);
      int res, lat;
      run_op(x, y, n, res, lat);
      check(mont_ok(x, y, n, res), "R2", $sformatf("x=%0d y=%0d n=%0d", x, y, n),
            res, mont_ref(x, y, n));
      check(lat == LAT, "R3", "latency", lat, LAT);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            tests++;
            fails++;
            $display("FAIL R3 watchdog: cycles=%0d expected<%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
         end
      end
   end

   initial begin
      int res, lat, ref_a, held;
      bit busy_ok;
      int small_n[4] = '{1, 3, 13, 31};
      int big_n[3]   = '{129, 251, 255};

      // R1: reset state
      repeat (3) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && result == '0, "R1", "under reset",
            {busy, done, 8'(result)}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && result == '0, "R1", "after release",
            {busy, done, 8'(result)}, 0);

      // R2/R3: exhaustive on small moduli
      foreach (small_n[i]) begin
         for (int x = 0; x < small_n[i]; x++) begin
            for (int y = 0; y < small_n[i]; y++) begin
               sweep_one(x, y, small_n[i]);
            end
         end
      end
      // R2/R3: strided sweep with edge operands on large moduli
      foreach (big_n[i]) begin
         for (int a = 0; a <= 16; a++) begin
            for (int b = 0; b <= 16; b++) begin
               sweep_one((a == 16) ? big_n[i] - 1 : (a * 15) % big_n[i],
                         (b == 16) ? big_n[i] - 1 : (b * 15) % big_n[i], big_n[i]);
            end
         end
      end

      // R9: zero operands
      run_op(0, 200, 251, res, lat);
      check(res == 0, "R9", "x zero", res, 0);
      run_op(250, 0, 251, res, lat);
      check(res == 0, "R9", "y zero", res, 0);

      // R6 / R4: start during run is ignored; busy stays high
      ref_a = mont_ref(200, 117, 251);
      @(negedge clk);
      op_x = 8'd200; op_y = 8'd117; modulus = 8'd251; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      busy_ok = 1'b1;
      while (!done && lat < 200) begin
         if (!busy) busy_ok = 1'b0;
         if (lat == 3) begin
            start = 1'b1; op_x = 8'd5; op_y = 8'd9; modulus = 8'd13;
         end else if (lat == 4) begin
            start = 1'b0;
         end
         @(negedge clk);
         lat++;
      end
      check(int'(result) == ref_a, "R6", "result after ignored start", int'(result), ref_a);
      check(lat == LAT, "R6", "latency after ignored start", lat, LAT);
      check(busy_ok, "R4", "busy during run", busy_ok, 1);
      check(busy == 1'b0, "R4", "busy with done", busy, 0);

      // R5: done is a single-cycle pulse
      held = int'(result);
      @(negedge clk);
      check(done == 1'b0, "R5", "done second cycle", done, 0);

      // R7: result holds while idle with inputs moving
      for (int k = 0; k < 6; k++) begin
         op_x = TW'(k * 37); op_y = TW'(k * 11); modulus = TW'(2 * k + 1);
         @(negedge clk);
      end
      check(int'(result) == held, "R7", "result hold", int'(result), held);

      // R8: operand inputs changed mid-run have no effect
      ref_a = mont_ref(77, 230, 251);
      @(negedge clk);
      op_x = 8'd77; op_y = 8'd230; modulus = 8'd251; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 0;
      while (!done && lat < 200) begin
         if (lat == 2) begin
            op_x = 8'd0; op_y = 8'd0; modulus = 8'd3;
         end
         @(negedge clk);
         lat++;
      end
      check(int'(result) == ref_a, "R8", "result with moving inputs", int'(result), ref_a);
      check(lat == LAT, "R3", "latency with moving inputs", lat, LAT);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule